// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This block performs lane-parallel addition and subtraction on a 32-bit word seen either as four unsigned bytes, two signed halfwords, two unsigned halfwords, or one signed 32-bit scalar. Each request carries two operands, an operation code, a lane type and a rounding bit. The operations are:

- wrapping add and subtract;
- saturating add and subtract;
- halving add and subtract, each with optional round-up;
- saturating absolute value.

The caller pulses a start strobe. On the next clock edge the packed result is registered and a done pulse is raised.

An overflow in any active lane sets a single sticky overflow bit. The arithmetic never clears this bit. Software clears it through a dedicated clear input. When a set and a clear land in the same cycle, the set takes precedence. The unit sits beside an execution pipeline and exchanges no handshake beyond the strobe.

Top module: `psa_unit`

## Requirements
- R1: A start pulse with its inputs is captured at that rising clock edge. `result_o` shows the packed answer and `done_o` is high for exactly the following cycle. Without start, `result_o` holds its value and `done_o` is low. Lane i of a type with lane width w occupies bits [w*i+w-1 : w*i].
- R2: Type codes are 0 = four unsigned 8-bit lanes, 1 = two signed 16-bit lanes, 2 = two unsigned 16-bit lanes, 3 = one signed 32-bit lane. Operation 0 (wrapping add) and operation 1 (wrapping subtract) return the lane result truncated to the lane width. Both still report lane overflow.
- R3: Operations 2 (saturating add) and 3 (saturating subtract) on signed lanes detect overflow as a true result outside the lane range. On overflow they return the lane maximum (0x7FFF or 0x7FFFFFFF) when operand a is non-negative, otherwise the lane minimum (0x8000 or 0x80000000).
- R4: Saturating add on unsigned lanes returns all ones when the lane carries out. Saturating subtract on unsigned lanes returns zero when the lane borrows. Both count as overflow.
- R5: Operations 4 (halving add) and 5 (halving subtract) form the sum or difference one bit wider than the lane. When `rnd_i` is 1 they add one. They then shift right by one, arithmetic for signed lanes. They never raise overflow.
- R6: Operation 6 (saturating absolute value) reads every lane of a as two's complement, on every type. It returns the magnitude, except that the most negative lane value becomes the most positive value and counts as overflow. Operand b is ignored.
- R7: `ovf_o` goes high at the edge that captures a start whose active lanes overflow in any lane. It stays high until it is cleared. Later arithmetic without overflow leaves it high.
- R8: `ovf_clr_i` high at an edge clears `ovf_o`, unless a start with overflow is captured at the same edge, in which case `ovf_o` is set.
- R9: Operation 7 is reserved. It returns zero and never raises overflow.
- R10: After synchronous active-low reset, `result_o`, `done_o` and `ovf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle per operation |
| op_i | input | 3 | Operation code (R2 to R9) |
| rnd_i | input | 1 | Round-up enable for halving operations |
| type_i | input | 2 | Lane type code (R2) |
| a_i | input | 32 | First packed operand |
| b_i | input | 32 | Second packed operand |
| ovf_clr_i | input | 1 | Clears the sticky overflow bit |
| result_o | output | 32 | Registered packed result |
| done_o | output | 1 | High for one cycle after a captured start |
| ovf_o | output | 1 | Sticky overflow bit |

## Verification
The packed result, the done pulse and any change of the sticky bit all become visible one register stage after the edge that captures the start. A clear behaves the same way, taking effect at the edge that samples it. The bench changes inputs on the falling edge and samples one full cycle later, on the next falling edge. It compares the sample with a lane-by-lane integer model computed in the bench. It also tracks the expected sticky bit, folding in clears and sets in the same order the rules state.

// File: rtl/psa_pkg.sv
// Shared encodings for the packed saturating add/subtract unit.
// Assumes a 3-bit operation code and a 2-bit lane-type code.
package psa_pkg;
    typedef enum logic [2:0] {
        OP_WADD = 3'd0,
        OP_WSUB = 3'd1,
        OP_SADD = 3'd2,
        OP_SSUB = 3'd3,
        OP_HADD = 3'd4,
        OP_HSUB = 3'd5,
        OP_ABS  = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        TY_U8X4  = 2'd0,
        TY_S16X2 = 2'd1,
        TY_U16X2 = 2'd2,
        TY_S32   = 2'd3
    } ty_e;
endpackage

// File: rtl/psa_lane.sv
// One arithmetic lane of width W.
// SGN selects signed (1) or unsigned (0) interpretation for add/sub.
// Purely combinational: y is the lane result and ovf flags overflow for this lane.
// Assumes W >= 2.
module psa_lane
    import psa_pkg::*;
#(
    parameter int W   = 8,
    parameter bit SGN = 1'b0
) (
    input  op_e            op,
    input  logic           rnd,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y,
    output logic           ovf
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] xa, xb, sum, dif, hsel, hres;
    logic       add_ov, sub_ov;
    logic [W-1:0] sat_val;

    // Widened sum/difference and lane overflow detection.
    always_comb begin
        xa     = {(SGN ? a[W-1] : 1'b0), a};
        xb     = {(SGN ? b[W-1] : 1'b0), b};
        sum    = xa + xb;
        dif    = xa - xb;
        add_ov = SGN ? (sum[W] ^ sum[W-1]) : sum[W];
        sub_ov = SGN ? (dif[W] ^ dif[W-1]) : dif[W];
        hsel   = (op == OP_HADD) ? sum : dif;
        hres   = hsel + {{W{1'b0}}, rnd};
        sat_val = a[W-1] ? SMIN : SMAX;
    end

    // Result selection per operation.
    always_comb begin
        y   = '0;
        ovf = 1'b0;
        case (op)
            OP_WADD: begin y = sum[W-1:0]; ovf = add_ov; end
            OP_WSUB: begin y = dif[W-1:0]; ovf = sub_ov; end
            OP_SADD: begin
                ovf = add_ov;
                if (add_ov) y = SGN ? sat_val : {W{1'b1}};
                else        y = sum[W-1:0];
            end
            OP_SSUB: begin
                ovf = sub_ov;
                if (sub_ov) y = SGN ? sat_val : {W{1'b0}};
                else        y = dif[W-1:0];
            end
            OP_HADD, OP_HSUB: begin y = hres[W:1]; ovf = 1'b0; end
            OP_ABS: begin
                if (a == SMIN) begin y = SMAX; ovf = 1'b1; end
                else           y = a[W-1] ? ({W{1'b0}} - a) : a;
            end
            default: begin y = '0; ovf = 1'b0; end
        endcase
    end
endmodule

// File: rtl/psa_sticky.sv
// Sticky overflow bit: set by an overflowing operation, cleared by software.
// A set and a clear in the same cycle leave the bit set.
module psa_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Sticky register update, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/psa_unit.sv
// Packed saturating add/subtract unit (top).
// Builds every lane type in parallel, selects one by type code, and
// registers the packed result one cycle after start.
// Assumes DATA_W is a multiple of 16.
module psa_unit
    import psa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic              rnd_i,
    input  logic [1:0]        type_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              ovf_clr_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              ovf_o
);
    localparam int N8  = DATA_W / 8;
    localparam int N16 = DATA_W / 16;

    op_e op;
    ty_e ty;
    assign op = op_e'(op_i);
    assign ty = ty_e'(type_i);

    logic [DATA_W-1:0] y_u8, y_s16, y_u16, y_s32, y_sel;
    logic [N8-1:0]     ov_u8;
    logic [N16-1:0]    ov_s16, ov_u16;
    logic              ov_s32, ov_any;

    // Byte lanes (unsigned).
    for (genvar g = 0; g < N8; g++) begin : g_u8
        psa_lane #(.W(8), .SGN(1'b0)) lane_i (
            .op(op), .rnd(rnd_i),
            .a(a_i[8*g +: 8]), .b(b_i[8*g +: 8]),
            .y(y_u8[8*g +: 8]), .ovf(ov_u8[g]));
    end

    // Halfword lanes, signed and unsigned variants.
    for (genvar g = 0; g < N16; g++) begin : g_h16
        psa_lane #(.W(16), .SGN(1'b1)) s_i (
            .op(op), .rnd(rnd_i),
            .a(a_i[16*g +: 16]), .b(b_i[16*g +: 16]),
            .y(y_s16[16*g +: 16]), .ovf(ov_s16[g]));
        psa_lane #(.W(16), .SGN(1'b0)) u_i (
            .op(op), .rnd(rnd_i),
            .a(a_i[16*g +: 16]), .b(b_i[16*g +: 16]),
            .y(y_u16[16*g +: 16]), .ovf(ov_u16[g]));
    end

    // Full-width signed scalar lane.
    psa_lane #(.W(DATA_W), .SGN(1'b1)) s32_i (
        .op(op), .rnd(rnd_i), .a(a_i), .b(b_i),
        .y(y_s32), .ovf(ov_s32));

    // Select result and overflow of the active lane type.
    always_comb begin
        case (ty)
            TY_U8X4:  begin y_sel = y_u8;  ov_any = |ov_u8;  end
            TY_S16X2: begin y_sel = y_s16; ov_any = |ov_s16; end
            TY_U16X2: begin y_sel = y_u16; ov_any = |ov_u16; end
            default:  begin y_sel = y_s32; ov_any = ov_s32;  end
        endcase
    end

    // Result and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) result_o <= y_sel;
        end
    end

    psa_sticky sticky_i (
        .clk(clk), .rst_n(rst_n),
        .set(start_i && ov_any), .clr(ovf_clr_i), .q(ovf_o));

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    a_r1_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));
    a_r5_half_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HADD || op == OP_HSUB) |-> !ov_any);
    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |-> (!ov_any && y_sel == '0));
endmodule

// File: tb/psa_unit_tb.sv
// Self-checking bench for psa_unit: directed corners plus seeded random.
module psa_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        rnd_i = 1'b0;
    logic [1:0]  type_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        ovf_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        done_o, ovf_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    bit  exp_flag = 0;

    always #10 clk = ~clk;

    psa_unit dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_lane(input int w, input bit sgn, input int op,
                                             input bit rnd, input logic [31:0] a,
                                             input logic [31:0] b, output bit ov);
        longint one = 1;
        longint m   = (one << w) - 1;
        longint half = one << (w - 1);
        longint va, vb, sa, mx, mn, t;
        va = longint'(a) & m;
        vb = longint'(b) & m;
        sa = (va >= half) ? va - (one << w) : va;
        if (sgn) begin
            if (va >= half) va = va - (one << w);
            if (vb >= half) vb = vb - (one << w);
        end
        mx = sgn ? half - 1 : m;
        mn = sgn ? -half : 0;
        ov = 0;
        t  = 0;
        case (op)
            0, 2: begin
                t = va + vb; ov = (t > mx) || (t < mn);
                if (op == 2) begin if (t > mx) t = mx; if (t < mn) t = mn; end
            end
            1, 3: begin
                t = va - vb; ov = (t > mx) || (t < mn);
                if (op == 3) begin if (t > mx) t = mx; if (t < mn) t = mn; end
            end
            4: t = (va + vb + longint'(rnd)) >>> 1;
            5: t = (va - vb + longint'(rnd)) >>> 1;
            6: begin
                if (sa == -half) begin t = half - 1; ov = 1; end
                else t = (sa < 0) ? -sa : sa;
            end
            default: t = 0;
        endcase
        return 32'(t & m);
    endfunction

    function automatic logic [31:0] ref_word(input int op, input int typ, input bit rnd,
                                             input logic [31:0] a, input logic [31:0] b,
                                             output bit ov);
        int w, n; bit sgn; logic [31:0] r; bit lo;
        case (typ)
            0: begin w = 8;  n = 4; sgn = 0; end
            1: begin w = 16; n = 2; sgn = 1; end
            2: begin w = 16; n = 2; sgn = 0; end
            default: begin w = 32; n = 1; sgn = 1; end
        endcase
        r = '0; ov = 0;
        for (int i = 0; i < n; i++) begin
            r = r | (ref_lane(w, sgn, op, rnd, a >> (i * w), b >> (i * w), lo) << (i * w));
            ov = ov | lo;
        end
        return r;
    endfunction

    function automatic string tag_of(input int op, input int typ);
        case (op)
            0, 1: return "R2";
            2, 3: return (typ == 1 || typ == 3) ? "R3" : "R4";
            4, 5: return "R5";
            6:    return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic do_op(input int op, input int typ, input bit rnd,
                         input logic [31:0] a, input logic [31:0] b, input bit clr);
        logic [31:0] exp; bit ov;
        @(negedge clk);
        op_i = 3'(op); type_i = 2'(typ); rnd_i = rnd; a_i = a; b_i = b;
        ovf_clr_i = clr; start_i = 1'b1;
        exp = ref_word(op, typ, rnd, a, b, ov);
        if (ov) exp_flag = 1;
        else if (clr) exp_flag = 0;
        @(negedge clk);
        start_i = 1'b0; ovf_clr_i = 1'b0;
        check(tag_of(op, typ), result_o, exp);
        check("R7 flag", {31'd0, ovf_o}, {31'd0, exp_flag});
        check("R1 done", {31'd0, done_o}, 32'd1);
    endtask

    task automatic clear_only();
        @(negedge clk);
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
        exp_flag = 0;
        check("R8 clear", {31'd0, ovf_o}, 32'd0);
    endtask

    function automatic logic [31:0] corner(input int typ, input int k);
        logic [15:0] h; logic [7:0] by;
        case (k)
            0: begin by = 8'h00; h = 16'h0000; end
            1: begin by = 8'h01; h = 16'h0001; end
            2: begin by = 8'hFF; h = 16'hFFFF; end
            3: begin by = 8'h80; h = 16'h8000; end
            default: begin by = 8'h7F; h = 16'h7FFF; end
        endcase
        if (typ == 0) return {4{by}};
        if (typ == 3) return (k == 3) ? 32'h80000000 : (k == 4) ? 32'h7FFFFFFF :
                             (k == 2) ? 32'hFFFFFFFF : {31'd0, k[0]};
        return {2{h}};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 result", result_o, 32'd0);
        check("R10 done", {31'd0, done_o}, 32'd0);
        check("R10 flag", {31'd0, ovf_o}, 32'd0);

        // R2: wrapping u8 add with carry in one lane only, flag still set
        do_op(0, 0, 0, 32'h01FF0010, 32'h01020003, 0);
        // R1: idle cycle holds result and drops done
        keep = result_o;
        @(negedge clk);
        check("R1 hold", result_o, keep);
        check("R1 done low", {31'd0, done_o}, 32'd0);
        // R7: non-overflowing op keeps the sticky bit
        do_op(0, 0, 0, 32'h01010101, 32'h01010101, 0);
        // R8: clear alone
        clear_only();
        // R8: clear together with overflowing op -> set wins
        do_op(2, 1, 0, 32'h7FFF0000, 32'h00010000, 1);
        // R8: clear together with quiet op -> cleared
        do_op(4, 1, 1, 32'h7FFF7FFF, 32'h7FFF7FFF, 1);
        // R3: signed sub with a = 0 and b = MIN saturates to MAX
        do_op(3, 1, 0, 32'h00000000, 32'h80008000, 0);
        // R6: abs of MIN on s32
        do_op(6, 3, 0, 32'h80000000, 32'h12345678, 0);
        // R9: reserved op
        clear_only();
        do_op(7, 0, 0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);

        // Corner sweep across types, values, operations
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    for (int o = 0; o < 7; o++)
                        do_op(o, t, bit'((i + j + o) & 1), corner(t, i), corner(t, j), 0);

        // Seeded random mix
        for (int n = 0; n < 1200; n++) begin
            int o = int'($urandom_range(0, 7));
            int t = int'($urandom_range(0, 3));
            do_op(o, t, bit'($urandom_range(0, 1)), $urandom, $urandom,
                  ($urandom_range(0, 15) == 0));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule